// File: doc/BRIEF.md
# Four-Group Interrupt Flag Aggregator

This block collects sixteen interrupt sources arranged as four groups of four. Each source is edge-sensitive. A rising edge on a source latches a pending flag for that source. Each group also holds an enable mask. A group raises its own request line whenever at least one of its pending flags is also enabled. The four request lines are meant to reach four successive processor priority levels: group 0 drives level 3, group 1 drives level 4, group 2 drives level 5 and group 3 drives level 6.

Software reaches the block through a byte-wide register port with a combinational read path and a single-cycle write strobe. Pending flags are cleared by writing ones. The enable mask does not use plain writes. Data bit 7 of a write chooses whether the ones in the low nibble set enable bits or clear them, so a single enable can be changed without a read-modify-write. A group is fully quietened by clearing all four enables and then writing 0x0F to its flag register.

Top module: `irq_group_aggregator`

## Requirements
- R1: While `rst` is high at a clock edge, every flag and enable bit is cleared, and `irq_req_o` reads 0 after that edge.
- R2: A source bit that was sampled low at one edge and high at the next sets its flag at that second edge, whatever its enable bit is. A source that stays high does not set its flag again after the flag has been cleared.
- R3: Writing to a flag register clears each flag whose data bit 3..0 is 1 and leaves the flags whose data bit is 0 unchanged.
- R4: Writing to an enable register with data bit 7 = 1 sets each enable bit whose data bit 3..0 is 1 and leaves the others unchanged.
- R5: Writing to an enable register with data bit 7 = 0 clears each enable bit whose data bit 3..0 is 1 and leaves the others unchanged.
- R6: `irq_req_o[g]` is 1 exactly when the AND of group g's flags and enables is non-zero. Bit 0 serves level 3, bit 1 level 4, bit 2 level 5 and bit 3 level 6.
- R7: When a rising edge and a clearing write hit the same flag at the same edge, the flag ends up set.
- R8: Group g's flag register is at address 0x30 + 0x10·g and its enable register at 0x34 + 0x10·g. Every other address reads 0, and writes to it change no state.
- R9: Read data carries the register's four bits in bits 3..0, with bits 7..4 equal to 0.
- R10: A write to one group's register leaves the flags and enables of the other three groups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 16 | Interrupt sources. Group g uses bits 4g+3..4g |
| bus_addr_i | input | 8 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| irq_req_o | output | 4 | Per-group request. Bits 0..3 serve levels 3..6 |

## Verification
A wrong flag or enable bit shows up as a wrong nibble on the very next read of that register, and as a request line that is wrong in the cycle after the bad edge. The sweeps therefore read back all eight registers and all four request lines after every stimulus. This catches an edge detector that re-triggers on a held level, a mode decode that inverts bit 7, and a write that leaks into a neighbouring group or an unmapped address, each within one cycle of the fault. The simultaneous set-and-clear case is driven for every bit pattern, because losing an event there leaves no other trace.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int IRQ_GROUPS  = 4;
    localparam int IRQ_SRCS    = 4;
    localparam int BUS_ADDR_W  = 8;
    localparam int BUS_DATA_W  = 8;
    localparam int GRP_IDX_W   = (IRQ_GROUPS > 1) ? $clog2(IRQ_GROUPS) : 1;

    localparam int MAP_BASE    = 'h30;
    localparam int MAP_STRIDE  = 'h10;
    localparam int MAP_EN_OFS  = 'h04;

    typedef enum logic [0:0] {
        REG_PEND   = 1'b0,
        REG_ENABLE = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic                 hit;
        logic [GRP_IDX_W-1:0] grp;
        reg_kind_e            kind;
    } reg_sel_t;

    // Enable update: mode bit high sets the selected bits, low clears them.
    function automatic logic [IRQ_SRCS-1:0] en_update(
        input logic [IRQ_SRCS-1:0] cur,
        input logic [IRQ_SRCS-1:0] sel,
        input logic                set_mode
    );
        return set_mode ? (cur | sel) : (cur & ~sel);
    endfunction

    function automatic logic [BUS_DATA_W-1:0] pad_nibble(input logic [IRQ_SRCS-1:0] v);
        logic [BUS_DATA_W-1:0] r;
        r = '0;
        r[IRQ_SRCS-1:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int GROUPS = IRQ_GROUPS,
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int BASE   = MAP_BASE,
    parameter int STRIDE = MAP_STRIDE,
    parameter int EN_OFS = MAP_EN_OFS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);

    logic [GROUPS-1:0] grp_hit;

    always_comb begin
        sel_o   = '0;
        grp_hit = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (int'(addr_i) == BASE + g * STRIDE) begin
                grp_hit[g] = 1'b1;
                sel_o.hit  = 1'b1;
                sel_o.grp  = GRP_IDX_W'(g);
                sel_o.kind = REG_PEND;
            end else if (int'(addr_i) == BASE + g * STRIDE + EN_OFS) begin
                grp_hit[g] = 1'b1;
                sel_o.hit  = 1'b1;
                sel_o.grp  = GRP_IDX_W'(g);
                sel_o.kind = REG_ENABLE;
            end
        end
    end

    AST_ONE_GROUP_PER_ADDR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grp_hit) && (sel_o.hit == (|grp_hit))); // R8

endmodule

// File: rtl/irqagg_group.sv
module irqagg_group
    import irqagg_pkg::*;
#(
    parameter int SRCS   = IRQ_SRCS,
    parameter int DATA_W = BUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRCS-1:0]   src_i,
    input  logic              wr_pend_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SRCS-1:0]   pend_o,
    output logic [SRCS-1:0]   en_o,
    output logic              req_o
);

    localparam int MODE_BIT = DATA_W - 1;

    logic [SRCS-1:0] src_q;
    logic [SRCS-1:0] evt;
    logic [SRCS-1:0] clr;
    logic [SRCS-1:0] pend_q;
    logic [SRCS-1:0] en_q;

    assign evt = src_i & ~src_q;
    assign clr = wr_pend_i ? wdata_i[SRCS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            src_q  <= src_i;
            // Event is OR-ed after the clear so a coincident event survives.
            pend_q <= (pend_q & ~clr) | evt;
            if (wr_en_i)
                en_q <= en_update(en_q, wdata_i[SRCS-1:0], wdata_i[MODE_BIT]);
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign req_o  = |(pend_q & en_q);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pend_q == '0 && en_q == '0)); // R1

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((pend_q & $past(evt)) == $past(evt))); // R7

    AST_W1C_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_pend_i && !(|evt)) |=>
            (pend_q == ($past(pend_q) & ~$past(wdata_i[SRCS-1:0])))); // R3

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wdata_i[MODE_BIT]) |=>
            ((en_q & $past(wdata_i[SRCS-1:0])) == $past(wdata_i[SRCS-1:0]))); // R4

    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wdata_i[MODE_BIT]) |=>
            ((en_q & $past(wdata_i[SRCS-1:0])) == '0)); // R5

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(en_q)); // R10

endmodule

// File: rtl/irq_group_aggregator.sv
module irq_group_aggregator
    import irqagg_pkg::*;
#(
    parameter int GROUPS = IRQ_GROUPS,
    parameter int SRCS   = IRQ_SRCS,
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [GROUPS*SRCS-1:0]   src_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic                     bus_wr_i,
    input  logic [DATA_W-1:0]        bus_wdata_i,
    output logic [DATA_W-1:0]        bus_rdata_o,
    output logic [GROUPS-1:0]        irq_req_o
);

    reg_sel_t        sel;
    logic [SRCS-1:0] pend [GROUPS];
    logic [SRCS-1:0] en   [GROUPS];

    irqagg_decode #(
        .GROUPS (GROUPS),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk    (clk),
        .rst    (rst),
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic wr_pend;
        logic wr_en;

        assign wr_pend = bus_wr_i && sel.hit && (int'(sel.grp) == g) && (sel.kind == REG_PEND);
        assign wr_en   = bus_wr_i && sel.hit && (int'(sel.grp) == g) && (sel.kind == REG_ENABLE);

        irqagg_group #(
            .SRCS   (SRCS),
            .DATA_W (DATA_W)
        ) u_group (
            .clk       (clk),
            .rst       (rst),
            .src_i     (src_i[g*SRCS +: SRCS]),
            .wr_pend_i (wr_pend),
            .wr_en_i   (wr_en),
            .wdata_i   (bus_wdata_i),
            .pend_o    (pend[g]),
            .en_o      (en[g]),
            .req_o     (irq_req_o[g])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (sel.hit && int'(sel.grp) == g)
                bus_rdata_o = (sel.kind == REG_ENABLE) ? pad_nibble(en[g]) : pad_nibble(pend[g]);
        end
    end

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_o[DATA_W-1:SRCS] == '0); // R9

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !sel.hit |-> bus_rdata_o == '0); // R8

    AST_REQ_QUIET_AFTER_RESET: assert property (@(posedge clk)
        rst |=> irq_req_o == '0); // R1

endmodule

// File: tb/tb_irq_group_aggregator.sv
module tb_irq_group_aggregator;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] src;
    logic [7:0]  addr;
    logic        wr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [3:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [3:0]  mf [4];
    logic [3:0]  me [4];
    logic [15:0] mprev;

    always #10 clk = ~clk;

    irq_group_aggregator dut (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_req_o   (irq)
    );

    function automatic logic [7:0] pend_addr(input int g);
        return 8'(8'h30 + 8'h10 * g);
    endfunction

    function automatic logic [7:0] en_addr(input int g);
        return 8'(8'h34 + 8'h10 * g);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus; the model follows R2..R5, R7, R8 and R10.
    task automatic tick(input logic [7:0] a, input logic w, input logic [7:0] d, input logic [15:0] s);
        logic [15:0] evt;
        @(negedge clk);
        addr = a; wr = w; wdata = d; src = s;
        @(posedge clk);
        #1;
        evt = s & ~mprev;
        mprev = s;
        for (int g = 0; g < 4; g++) begin
            if (w && a == pend_addr(g)) mf[g] = mf[g] & ~d[3:0];
            mf[g] = mf[g] | evt[g*4 +: 4];
            if (w && a == en_addr(g))
                me[g] = d[7] ? (me[g] | d[3:0]) : (me[g] & ~d[3:0]);
        end
        wr = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int g = 0; g < 4; g++) begin
            addr = pend_addr(g); #1;
            check({tag, " pend R9"}, rdata, {4'h0, mf[g]});
            addr = en_addr(g); #1;
            check({tag, " en R9"}, rdata, {4'h0, me[g]});
            check({tag, " req R6"}, {7'h0, irq[g]}, {7'h0, |(mf[g] & me[g])});
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; src = '0; addr = '0; wr = 1'b0; wdata = '0;
        mprev = '0;
        for (int g = 0; g < 4; g++) begin mf[g] = '0; me[g] = '0; end
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        check("R1 irq after reset", {4'h0, irq}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R4 R5 R10: enable set/clear sweep over every pattern in every group
        for (int g = 0; g < 4; g++) begin
            for (int d = 0; d < 16; d++) begin
                tick(en_addr(g), 1'b1, 8'h80 | 8'(d), 16'h0);
                check_all("R4 set");
                tick(en_addr(g), 1'b1, 8'(d), 16'h0);
                check_all("R5 clear");
            end
        end

        // R8: unmapped addresses read zero and ignore writes
        tick(en_addr(2), 1'b1, 8'h8A, 16'h0);
        foreach (mf[i]) begin end
        tick(8'h35, 1'b1, 8'hFF, 16'h0);
        tick(8'h00, 1'b1, 8'h8F, 16'h0);
        tick(8'h70, 1'b1, 8'h8F, 16'h0);
        tick(8'h2C, 1'b1, 8'h0F, 16'h0);
        check_all("R8 unmapped write");
        addr = 8'h35; #1; check("R8 read 0x35", rdata, 8'h00);
        addr = 8'h74; #1; check("R8 read 0x74", rdata, 8'h00);
        addr = 8'h3F; #1; check("R8 read 0x3F", rdata, 8'h00);

        // R2 R3 R6: edges set flags regardless of enables; held level does not re-set
        for (int g = 0; g < 4; g++) begin
            for (int p = 1; p < 16; p++) begin
                tick(en_addr(g), 1'b1, 8'h0F, 16'h0);
                tick(en_addr(g), 1'b1, 8'h80 | 8'(p ^ 5), 16'h0);
                tick(8'h00, 1'b0, 8'h00, 16'(p) << (4 * g));
                check_all("R2 edge");
                tick(pend_addr(g), 1'b1, 8'h0F, 16'(p) << (4 * g));
                check_all("R2 held R3");
                tick(8'h00, 1'b0, 8'h00, 16'h0);
                check_all("R2 fall");
            end
        end

        // R3: partial write-one-to-clear
        for (int g = 0; g < 4; g++) begin
            for (int d = 0; d < 16; d++) begin
                tick(8'h00, 1'b0, 8'h00, 16'h0);
                tick(en_addr(g), 1'b1, 8'h8F, 16'hF << (4 * g));
                tick(pend_addr(g), 1'b1, 8'(d), 16'hF << (4 * g));
                check_all("R3 partial clear");
                tick(pend_addr(g), 1'b1, 8'h0F, 16'h0);
            end
        end

        // R7: set wins over a coincident clear
        for (int g = 0; g < 4; g++) begin
            for (int d = 1; d < 16; d++) begin
                tick(8'h00, 1'b0, 8'h00, 16'h0);
                tick(pend_addr(g), 1'b1, 8'h0F, 16'(d) << (4 * g));
                check_all("R7 set wins");
                tick(pend_addr(g), 1'b1, 8'h0F, 16'h0);
            end
        end

        // R1: reset mid-run clears pending state and requests
        tick(en_addr(1), 1'b1, 8'h8F, 16'h00F0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        for (int g = 0; g < 4; g++) begin mf[g] = '0; me[g] = '0; end
        mprev = '0;
        check_all("R1 mid reset");
        @(negedge clk); rst = 1'b0; src = '0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule